// File: doc/BRIEF.md
# PCI Configuration Space with Base Address and Expansion ROM Registers

This block holds the 256-byte configuration space of one PCI function as 64 dwords. A configuration access port writes into it with byte, word or dword accesses and reads whole dwords back by dword index. Most of the space is plain storage. The six base address registers (dword indices 4 to 9, byte offsets 0x10 to 0x27) and the expansion ROM base register (dword index 12, byte offset 0x30) are handled by their own rules.

Each base address register slot is set up by parameters. A slot can be absent, or present with a power-of-two window size and a reset default. Bit 0 of that default fixes the type: 1 means I/O and 0 means memory. A register reads back its size mask when software sizes it. A memory register always returns to its default. An I/O register can be moved. When it moves, the block raises a one-cycle relocation event that carries the slot number and the old and new 16-bit port bases, so that the decoder outside the block can move its window.

Top module: `cfgsp_bar_unit`

## Requirements
- R1: After reset, each present base address register reads its parameter default. Every other dword, including the ROM register (index 12) and the absent slots, reads zero.
- R2: A byte write (wr_size 0) stores wr_data[7:0] into byte lane wr_off[1:0] of dword wr_off[7:2]. The other three lanes keep their values.
- R3: A word write (wr_size 1) stores wr_data[15:0] into the half selected by wr_off[1] (0 selects bits 15:0). A word write whose dword index is 4 to 10 (byte offsets 0x10 to 0x2B) is discarded and changes nothing.
- R4: A dword write (wr_size 2) outside indices 4 to 9 and index 12 stores the whole value. wr_off[1:0] is ignored.
- R5: A dword write to a present slot is a size probe when (data OR 3 OR (size-1)) is all ones. The slot then reads NOT(size-1) with the type bit in bit 0, and no relocation event follows.
- R6: Any dword write to a present memory slot that is not a probe leaves the slot reading its default.
- R7: A dword write to a present I/O slot that is not a probe stores the data with bit 0 set. In the next cycle reloc_vld is high for one cycle. reloc_bar gives the slot number (0 to 5). reloc_old is the slot's previous value, bits 15:0 with bit 0 cleared. reloc_new is the written data, bits 15:0 with bit 0 cleared.
- R8: A dword write to an absent slot leaves it reading zero.
- R9: With a ROM configured, a dword write to index 12 that has bits 31:11 all set reads back as zero minus the ROM size. Any other dword write to index 12 reads back as the fixed ROM address.
- R10: With no ROM configured (size 0), every dword write to index 12 leaves it reading zero.
- R11: reloc_vld is raised only in the cycle after a dword write that hits a present I/O slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_size | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 ignored |
| wr_off | input | 8 | Byte offset within the configuration space |
| wr_data | input | 32 | Write data, low-aligned for byte and word |
| rd_idx | input | 6 | Dword index to read |
| rd_data | output | 32 | Current value of the indexed dword, combinational |
| reloc_vld | output | 1 | One-cycle I/O relocation event |
| reloc_bar | output | 3 | Slot number of the relocated register |
| reloc_old | output | 16 | Port base before the write |
| reloc_new | output | 16 | Port base after the write |

## Verification
On every cycle the assertions check the following. A memory slot holds either its default or its probe mask after any dword write. An absent slot holds zero. An I/O slot keeps bit 0 set. A dropped word write never reaches the storage. A probe is never followed by a relocation event, and each event's new base matches the stored register. Only the bench scenarios can show the exact values: the probe masks, the old base seen after a probe, byte and word lane placement, and both ROM variants, checked against values worked out from the requirements.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_WORD  = 2'd1,
    ACC_DWORD = 2'd2
  } acc_size_e;

  localparam int unsigned NUM_BARS       = 6;
  localparam int unsigned BAR_FIRST_IDX  = 4;
  localparam int unsigned WORD_DROP_LAST = 10;
  localparam int unsigned ROM_IDX        = 12;
  localparam int unsigned ROM_LOW_BITS   = 11;

  // Sizing test: every bit outside the size window (and bits 1:0) written as one.
  function automatic logic is_size_probe(input logic [31:0] v, input logic [31:0] sz);
    return (v | 32'h3 | (sz - 32'd1)) == 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] probe_reply(input logic [31:0] sz, input logic io);
    return ~(sz - 32'd1) | {31'd0, io};
  endfunction

  function automatic logic [15:0] io_base(input logic [31:0] v);
    return v[15:0] & 16'hFFFE;
  endfunction

  function automatic logic is_rom_probe(input logic [31:0] v);
    return (v | ((32'd1 << ROM_LOW_BITS) - 32'd1)) == 32'hFFFF_FFFF;
  endfunction

  function automatic logic size_ok(input logic [31:0] sz);
    return (sz >= 32'd4) && ((sz & (sz - 32'd1)) == 32'd0);
  endfunction

endpackage

// File: rtl/cfgsp_decode.sv
module cfgsp_decode
  import cfgsp_pkg::*;
#(
  parameter int unsigned OFFW = 8,
  parameter int unsigned IDXW = OFFW - 2
) (
  input  logic                wr_en,
  input  logic [1:0]          wr_size,
  input  logic [OFFW-1:0]     wr_off,
  input  logic [31:0]         wr_data,
  output logic                gen_we,
  output logic [IDXW-1:0]     gen_idx,
  output logic [3:0]          gen_mask,
  output logic [31:0]         gen_data,
  output logic [NUM_BARS-1:0] bar_hit,
  output logic                rom_hit,
  output logic                word_drop
);

  logic [IDXW-1:0] idx;
  logic            in_word_win;

  assign idx         = wr_off[OFFW-1:2];
  assign in_word_win = (idx >= IDXW'(BAR_FIRST_IDX)) && (idx <= IDXW'(WORD_DROP_LAST));

  always_comb begin
    gen_we    = 1'b0;
    gen_idx   = idx;
    gen_mask  = 4'h0;
    gen_data  = wr_data;
    bar_hit   = '0;
    rom_hit   = 1'b0;
    word_drop = 1'b0;
    if (wr_en) begin
      case (wr_size)
        ACC_BYTE: begin
          gen_we   = 1'b1;
          gen_mask = 4'b0001 << wr_off[1:0];
          gen_data = {4{wr_data[7:0]}};
        end
        ACC_WORD: begin
          if (in_word_win) begin
            word_drop = 1'b1;
          end else begin
            gen_we   = 1'b1;
            gen_mask = wr_off[1] ? 4'b1100 : 4'b0011;
            gen_data = {2{wr_data[15:0]}};
          end
        end
        ACC_DWORD: begin
          for (int b = 0; b < NUM_BARS; b++) begin
            if (idx == IDXW'(BAR_FIRST_IDX + b)) bar_hit[b] = 1'b1;
          end
          if (idx == IDXW'(ROM_IDX)) begin
            rom_hit = 1'b1;
          end else if (bar_hit == '0) begin
            gen_we   = 1'b1;
            gen_mask = 4'hF;
          end
        end
        default: ;
      endcase
    end
  end

  // At most one destination class per access.
  always_comb begin
    AST_ONE_CLASS: assert ($onehot0({gen_we, |bar_hit, rom_hit, word_drop})); // R4
  end

endmodule

// File: rtl/cfgsp_bar_slot.sv
module cfgsp_bar_slot
  import cfgsp_pkg::*;
#(
  parameter logic        PRESENT = 1'b1,
  parameter logic [31:0] SIZE    = 32'h10,
  parameter logic [31:0] DEFAULT = 32'h0
) (
  input  logic        hit,
  input  logic [31:0] wdata,
  input  logic [31:0] cur,
  output logic [31:0] nval,
  output logic        probe,
  output logic        reloc,
  output logic [15:0] old_b,
  output logic [15:0] new_b
);

  localparam logic IS_IO = DEFAULT[0];

  assign old_b = io_base(cur);
  assign new_b = io_base(wdata);

  if (PRESENT) begin : g_present
    initial begin
      if (!size_ok(SIZE)) $error("slot size must be a power of two of at least 4");
    end

    always_comb begin
      probe = hit && is_size_probe(wdata, SIZE);
      reloc = 1'b0;
      if (is_size_probe(wdata, SIZE)) begin
        nval = probe_reply(SIZE, IS_IO);
      end else if (IS_IO) begin
        nval  = wdata | 32'd1;
        reloc = hit;
      end else begin
        nval = DEFAULT;
      end
    end
  end else begin : g_absent
    assign nval  = 32'd0;
    assign probe = 1'b0;
    assign reloc = 1'b0;
  end

endmodule

// File: rtl/cfgsp_store.sv
module cfgsp_store
  import cfgsp_pkg::*;
#(
  parameter int unsigned          DEPTH        = 64,
  parameter int unsigned          IDXW         = $clog2(DEPTH),
  parameter logic [NUM_BARS-1:0]  BAR_PRESENT  = '0,
  parameter logic [NUM_BARS*32-1:0] BAR_DEFAULTS = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [3:0]      wmask,
  input  logic [31:0]     wdata,
  input  logic [IDXW-1:0] ridx,
  output logic [31:0]     rdata,
  output logic [31:0]     dw_q [DEPTH]
);

  function automatic logic [31:0] reset_word(input int unsigned i);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < NUM_BARS; b++) begin
      if (i == BAR_FIRST_IDX + b && BAR_PRESENT[b]) r = BAR_DEFAULTS[b*32 +: 32];
    end
    return r;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_dw
    localparam logic [31:0] RV = reset_word(g);
    logic [31:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= RV;
      end else if (we && widx == IDXW'(g)) begin
        for (int l = 0; l < 4; l++) begin
          if (wmask[l]) q[l*8 +: 8] <= wdata[l*8 +: 8];
        end
      end
    end

    assign dw_q[g] = q;
  end

  assign rdata = dw_q[ridx];

endmodule

// File: rtl/cfgsp_bar_unit.sv
module cfgsp_bar_unit
  import cfgsp_pkg::*;
#(
  parameter int unsigned            CFG_BYTES    = 256,
  parameter logic [NUM_BARS-1:0]    BAR_PRESENT  = 6'b010011,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZES    = {32'h0, 32'h100, 32'h0, 32'h0, 32'h20, 32'h1000},
  parameter logic [NUM_BARS*32-1:0] BAR_DEFAULTS = {32'h0, 32'h0000_D001, 32'h0, 32'h0, 32'h0000_C001, 32'hFEB0_0000},
  parameter logic [31:0]            ROM_SIZE     = 32'h0001_0000,
  parameter logic [31:0]            ROM_ADDR     = 32'hFEB8_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_size,
  input  logic [7:0]  wr_off,
  input  logic [31:0] wr_data,
  input  logic [5:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic        reloc_vld,
  output logic [2:0]  reloc_bar,
  output logic [15:0] reloc_old,
  output logic [15:0] reloc_new
);

  localparam int unsigned DEPTH = CFG_BYTES / 4;
  localparam int unsigned OFFW  = $clog2(CFG_BYTES);
  localparam int unsigned IDXW  = $clog2(DEPTH);

  // Decode
  logic                gen_we;
  logic [IDXW-1:0]     gen_idx;
  logic [3:0]          gen_mask;
  logic [31:0]         gen_data;
  logic [NUM_BARS-1:0] bar_hit;
  logic                rom_hit;
  logic                word_drop;

  cfgsp_decode #(.OFFW(OFFW), .IDXW(IDXW)) dec_i (
    .wr_en     (wr_en),
    .wr_size   (wr_size),
    .wr_off    (wr_off),
    .wr_data   (wr_data),
    .gen_we    (gen_we),
    .gen_idx   (gen_idx),
    .gen_mask  (gen_mask),
    .gen_data  (gen_data),
    .bar_hit   (bar_hit),
    .rom_hit   (rom_hit),
    .word_drop (word_drop)
  );

  // Storage
  logic            st_we;
  logic [IDXW-1:0] st_idx;
  logic [3:0]      st_mask;
  logic [31:0]     st_data;
  logic [31:0]     dw_q [DEPTH];

  cfgsp_store #(
    .DEPTH        (DEPTH),
    .IDXW         (IDXW),
    .BAR_PRESENT  (BAR_PRESENT),
    .BAR_DEFAULTS (BAR_DEFAULTS)
  ) store_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .widx  (st_idx),
    .wmask (st_mask),
    .wdata (st_data),
    .ridx  (rd_idx),
    .rdata (rd_data),
    .dw_q  (dw_q)
  );

  // Base address register slots
  logic [31:0] slot_nval  [NUM_BARS];
  logic [15:0] slot_old   [NUM_BARS];
  logic [15:0] slot_new   [NUM_BARS];
  logic [NUM_BARS-1:0] slot_probe;
  logic [NUM_BARS-1:0] slot_reloc;

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_slot
    cfgsp_bar_slot #(
      .PRESENT (BAR_PRESENT[b]),
      .SIZE    (BAR_SIZES[b*32 +: 32]),
      .DEFAULT (BAR_DEFAULTS[b*32 +: 32])
    ) slot_i (
      .hit   (bar_hit[b]),
      .wdata (wr_data),
      .cur   (dw_q[BAR_FIRST_IDX + b]),
      .nval  (slot_nval[b]),
      .probe (slot_probe[b]),
      .reloc (slot_reloc[b]),
      .old_b (slot_old[b]),
      .new_b (slot_new[b])
    );
  end

  // Expansion ROM register
  logic [31:0] rom_next;
  always_comb begin
    if (ROM_SIZE == 32'd0)          rom_next = 32'd0;
    else if (is_rom_probe(wr_data)) rom_next = 32'd0 - ROM_SIZE;
    else                            rom_next = ROM_ADDR;
  end

  // Write steering
  always_comb begin
    st_we   = gen_we;
    st_idx  = gen_idx;
    st_mask = gen_mask;
    st_data = gen_data;
    if (rom_hit) begin
      st_we   = 1'b1;
      st_idx  = IDXW'(ROM_IDX);
      st_mask = 4'hF;
      st_data = rom_next;
    end
    for (int b = 0; b < NUM_BARS; b++) begin
      if (bar_hit[b]) begin
        st_we   = 1'b1;
        st_idx  = IDXW'(BAR_FIRST_IDX + b);
        st_mask = 4'hF;
        st_data = slot_nval[b];
      end
    end
  end

  // Relocation event, old base taken before the register updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reloc_vld <= 1'b0;
      reloc_bar <= '0;
      reloc_old <= '0;
      reloc_new <= '0;
    end else begin
      reloc_vld <= |slot_reloc;
      for (int b = 0; b < NUM_BARS; b++) begin
        if (slot_reloc[b]) begin
          reloc_bar <= 3'(b);
          reloc_old <= slot_old[b];
          reloc_new <= slot_new[b];
        end
      end
    end
  end

  logic probe_any;
  logic [IDXW-1:0] reloc_idx;
  assign probe_any = |slot_probe;
  assign reloc_idx = IDXW'(BAR_FIRST_IDX) + IDXW'(reloc_bar);

  AST_NO_STORE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    word_drop |-> !st_we); // R3

  AST_PROBE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    probe_any |=> !reloc_vld); // R5

  AST_EVENT_AFTER_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
    reloc_vld |-> $past(wr_en && wr_size == 2'(ACC_DWORD))); // R11

  AST_EVENT_NEW_IN_REG: assert property (@(posedge clk) disable iff (!rst_n)
    reloc_vld |-> reloc_new == io_base(dw_q[reloc_idx])); // R7

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_chk
    localparam logic [31:0] SZ  = BAR_SIZES[b*32 +: 32];
    localparam logic [31:0] DEF = BAR_DEFAULTS[b*32 +: 32];
    if (!BAR_PRESENT[b]) begin : g_abs
      AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bar_hit[b] |=> dw_q[BAR_FIRST_IDX + b] == 32'd0); // R8
    end else if (DEF[0]) begin : g_io
      AST_IO_TYPE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        bar_hit[b] |=> dw_q[BAR_FIRST_IDX + b][0]); // R7
    end else begin : g_mem
      AST_MEM_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        bar_hit[b] |=> (dw_q[BAR_FIRST_IDX + b] == DEF ||
                        dw_q[BAR_FIRST_IDX + b] == probe_reply(SZ, 1'b0))); // R6
    end
  end

endmodule

// File: tb/cfgsp_bar_unit_tb_top.sv
`timescale 1ns/100ps
module cfgsp_bar_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = 2'd0;
  logic [7:0]  wr_off = 8'd0;
  logic [31:0] wr_data = 32'd0;
  logic [5:0]  rd_idx = 6'd0;
  logic [31:0] rd_data, rd_data_nr;
  logic        reloc_vld, reloc_vld_nr;
  logic [2:0]  reloc_bar, reloc_bar_nr;
  logic [15:0] reloc_old, reloc_new, reloc_old_nr, reloc_new_nr;

  always #2.5 clk = ~clk;

  cfgsp_bar_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size), .wr_off(wr_off),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .reloc_vld(reloc_vld),
    .reloc_bar(reloc_bar), .reloc_old(reloc_old), .reloc_new(reloc_new)
  );

  cfgsp_bar_unit #(.ROM_SIZE(32'd0)) dut_nr_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size), .wr_off(wr_off),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data_nr), .reloc_vld(reloc_vld_nr),
    .reloc_bar(reloc_bar_nr), .reloc_old(reloc_old_nr), .reloc_new(reloc_new_nr)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_push = 0;
  int n_done = 0;
  bit finished = 0;

  // Scoreboard queues
  int          rq_idx [$];
  logic [31:0] rq_exp [$];
  string       rq_tag [$];
  logic [34:0] ev_q   [$];

  task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Read monitor: pops expectations, reads the dword away from the edge
  initial begin
    forever begin
      wait (rq_idx.size() != 0);
      @(negedge clk);
      rd_idx = 6'(rq_idx[0]);
      #1;
      note(rd_data === rq_exp[0], rq_tag[0], rd_data, rq_exp[0]);
      void'(rq_idx.pop_front());
      void'(rq_exp.pop_front());
      void'(rq_tag.pop_front());
      n_done++;
    end
  end

  // Event monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && reloc_vld) begin
        if (ev_q.size() == 0) begin
          note(1'b0, "R11 unexpected event", {13'd0, reloc_bar, reloc_new}, 32'd0);
        end else begin
          note({reloc_bar, reloc_old, reloc_new} === ev_q[0], "R7 event",
               {13'd0, reloc_bar, reloc_new}, {13'd0, ev_q[0][34:32], ev_q[0][15:0]});
          note(reloc_old === ev_q[0][31:16], "R7 old base", {16'd0, reloc_old}, {16'd0, ev_q[0][31:16]});
          void'(ev_q.pop_front());
        end
      end
    end
  end

  task automatic expect_rd(input int idx, input logic [31:0] exp, input string tag);
    rq_idx.push_back(idx);
    rq_exp.push_back(exp);
    rq_tag.push_back(tag);
    n_push++;
    wait (n_done == n_push);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_size = sz; wr_off = off; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ev(input logic [2:0] b, input logic [15:0] o, input logic [15:0] n);
    ev_q.push_back({b, o, n});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset image
    expect_rd(0,  32'h0,          "R1 idx0");
    expect_rd(4,  32'hFEB0_0000,  "R1 mem slot default");
    expect_rd(5,  32'h0000_C001,  "R1 io slot default");
    expect_rd(6,  32'h0,          "R1 absent slot");
    expect_rd(8,  32'h0000_D001,  "R1 io slot4 default");
    expect_rd(12, 32'h0,          "R1 rom reg");

    // R2 byte lanes
    wr(2'd0, 8'h3D, 32'hFFFF_FF01);
    expect_rd(15, 32'h0000_0100, "R2 byte lane1");
    wr(2'd0, 8'h3C, 32'h0000_000B);
    expect_rd(15, 32'h0000_010B, "R2 byte lane0");

    // R3 word halves and drop window
    wr(2'd1, 8'h3E, 32'h0000_ABCD);
    expect_rd(15, 32'hABCD_010B, "R3 upper half");
    wr(2'd1, 8'h10, 32'h0000_1111);
    expect_rd(4, 32'hFEB0_0000, "R3 dropped in slot");
    wr(2'd1, 8'h2A, 32'h0000_5555);
    expect_rd(10, 32'h0, "R3 dropped at 0x2A");

    // R4 dword generic
    wr(2'd2, 8'h2B, 32'h1234_5678);
    expect_rd(10, 32'h1234_5678, "R4 idx10 low bits ignored");
    wr(2'd2, 8'h05, 32'hCAFE_BABE);
    expect_rd(1, 32'hCAFE_BABE, "R4 idx1");

    // R5 probes
    wr(2'd2, 8'h10, 32'hFFFF_FFFF);
    expect_rd(4, 32'hFFFF_F000, "R5 mem probe");
    wr(2'd2, 8'h20, 32'hFFFF_FFFF);
    expect_rd(8, 32'hFFFF_FF01, "R5 io probe");

    // R6 memory slot reverts
    wr(2'd2, 8'h10, 32'h0000_1234);
    expect_rd(4, 32'hFEB0_0000, "R6 mem revert");

    // R7 relocation
    ev(3'd1, 16'hC000, 16'hE000);
    wr(2'd2, 8'h14, 32'h0000_E000);
    expect_rd(5, 32'h0000_E001, "R7 io stored");
    ev(3'd4, 16'hFF00, 16'hD800);
    wr(2'd2, 8'h20, 32'h0012_D801);
    expect_rd(8, 32'h0012_D801, "R7 io after probe");
    wr(2'd2, 8'h14, 32'hFFFF_FFF0);
    expect_rd(5, 32'hFFFF_FFE1, "R5 io probe partial");
    ev(3'd1, 16'hFFE0, 16'hC000);
    wr(2'd2, 8'h14, 32'h0000_C000);
    expect_rd(5, 32'h0000_C001, "R7 io back");

    // R8 absent slot
    wr(2'd2, 8'h18, 32'hFFFF_FFFF);
    expect_rd(6, 32'h0, "R8 absent probe");
    wr(2'd2, 8'h24, 32'h0000_1234);
    expect_rd(9, 32'h0, "R8 absent write");

    // R9 / R10 ROM
    wr(2'd2, 8'h30, 32'hFFFF_F800);
    expect_rd(12, 32'hFFFF_0000, "R9 rom probe");
    note(rd_data_nr === 32'h0, "R10 no rom probe", rd_data_nr, 32'h0);
    wr(2'd2, 8'h30, 32'h0000_0001);
    expect_rd(12, 32'hFEB8_0000, "R9 rom address");
    note(rd_data_nr === 32'h0, "R10 no rom write", rd_data_nr, 32'h0);

    repeat (4) @(negedge clk);
    note(ev_q.size() == 0, "R11 missing event", 32'(ev_q.size()), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule